// File: doc/BRIEF.md
# Reorder Buffer Retire Window

This block is the in-order back end of an out-of-order core's reorder buffer. Instructions enter at the tail with a few attributes: kind of memory operation, register class, and the physical register their destination displaced. Execution units later mark entries complete or faulting through a completion port. Address generation marks memory operations as having a known address, possibly with a structural hazard still pending.

Every cycle the block looks at a small window of the oldest entries. It walks that window from the oldest entry and stops after the first entry that is unfinished or faulting. Stores and uncached loads it meets on that walk are released toward the memory queue. Stores are released only while a store-buffer credit is free. In non-blocking-write mode a plain store counts as finished as soon as it is released.

Independently, the oldest entry retires once it has been finished for a configured number of cycles and is not still waiting on the memory unit. A normal retirement hands the displaced register back to the free list of its class. A faulting entry is reported instead. A flush input empties the buffer in one cycle.

Top module: `rob_retire_window`

## Requirements
- R1: While fewer than DEPTH entries are held, `alloc_ready` is 1 and an `alloc_valid` writes an entry at index `alloc_tag`, which then advances by one modulo DEPTH. With DEPTH entries held, `alloc_ready` is 0 and a request is dropped, leaving `alloc_tag` unchanged.
- R2: The release walk covers at most RET_W of the oldest held entries, starting at the head. Each entry on the walk is considered for release. The walk ends after any entry that is not complete or that is faulting. Bit k of `rel_valid`, `rel_drop` and field k of `rel_idx` (IW bits at position k*IW) refer to entry head+k.
- R3: A store on the walk is released when all of these hold: its address is known, no structural hazard is flagged, it was not released before, and the running count of released-but-unissued stores is below SB_CAP. Each non-faulting store release adds one to that count. A pulse on `st_issue` subtracts one if the count is nonzero.
- R4: With `nb_mode` 1, a released non-faulting store that is not read-modify-write becomes complete in the same clock edge. Otherwise a store becomes complete only through the completion port.
- R5: A faulting store or uncached load that is released raises its `rel_drop` bit. A faulting store consumes no credit.
- R6: An uncached load on the walk is released under the store conditions, except that the credit limit does not apply.
- R7: The head entry retires when it is complete or faulting and RET_LAT clock edges have passed since it became so. At most one entry retires per cycle.
- R8: A head store or uncached load that is not faulting and not yet released does not retire.
- R9: A faulting head entry retires with `exc_valid` 1 and `exc_idx` equal to its index. No register is returned for it.
- R10: A non-faulting retirement returns the entry's displaced register on `fp_free_*` for the floating-point class. For the integer class it uses `int_free_*`, except that integer register 0 is never returned.
- R11: A non-faulting barrier retirement pulses `bar_pop`. `sync_busy` goes to 1 the edge after a barrier is allocated. It goes to 0 the edge after a barrier retires, unless another barrier is allocated in the same cycle.
- R12: `flush` empties the buffer, zeroes the store credit count and clears `sync_busy` at the next edge. It takes priority over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the buffer |
| nb_mode | input | 1 | Non-blocking store mode |
| alloc_valid | input | 1 | Allocate request |
| alloc_is_st | input | 1 | New entry is a store |
| alloc_is_ucld | input | 1 | New entry is an uncached load |
| alloc_is_rmw | input | 1 | New store is read-modify-write |
| alloc_is_bar | input | 1 | New entry is a barrier |
| alloc_fp | input | 1 | Displaced register is floating-point |
| alloc_preg | input | PW | Displaced physical register |
| alloc_ready | output | 1 | Buffer can accept |
| alloc_tag | output | IW | Index given to the new entry |
| cmp_valid | input | 1 | Completion write |
| cmp_idx | input | IW | Completing entry |
| cmp_exc | input | 1 | Completion carries a fault |
| agen_valid | input | 1 | Address-known write |
| agen_idx | input | IW | Entry whose address is known |
| agen_sdep | input | 1 | Structural hazard still pending |
| st_issue | input | 1 | Memory queue issued one store |
| rel_valid | output | RET_W | Release strobe per window slot |
| rel_drop | output | RET_W | Released operation is faulting |
| rel_idx | output | RET_W*IW | Entry index per window slot |
| int_free_valid | output | 1 | Integer register returned |
| int_free_reg | output | PW | Returned integer register |
| fp_free_valid | output | 1 | Floating-point register returned |
| fp_free_reg | output | PW | Returned floating-point register |
| exc_valid | output | 1 | Faulting entry retired |
| exc_idx | output | IW | Index of that entry |
| bar_pop | output | 1 | Barrier retired |
| sync_busy | output | 1 | A barrier is pending |

## Verification
The assertions assume that completion and address writes name entries that are currently held. They also assume that a store is released at most once per allocation, which the release logic itself enforces through the released flag. The stimulus picks completion and address targets only from entries the bench model holds. It raises `st_issue` at random, but it relies on the design ignoring that pulse when the count is zero rather than avoiding it. Faults, flushes and mode changes are kept sparse, so that long runs of stores reach the credit limit.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef struct packed {
        logic valid;
        logic done;
        logic exc;
        logic is_st;
        logic is_ucld;
        logic is_rmw;
        logic is_bar;
        logic fp;
        logic addr_ok;
        logic sdep;
        logic rdy;
        logic in_mem;
    } rob_flags_t;

    function automatic rob_flags_t new_entry(logic st, logic ld, logic rmw, logic bar, logic fp);
        rob_flags_t f;
        f         = '0;
        f.valid   = 1'b1;
        f.is_st   = st;
        f.is_ucld = ld;
        f.is_rmw  = rmw;
        f.is_bar  = bar;
        f.fp      = fp;
        f.in_mem  = st | ld;
        return f;
    endfunction

endpackage

// File: rtl/rob_release_scan.sv
module rob_release_scan
    import rob_pkg::*;
#(
    parameter int RET_W  = 4,
    parameter int SB_CAP = 8,
    localparam int CW    = $clog2(SB_CAP + 1),
    localparam int AVW   = $clog2(RET_W + 1)
) (
    input  rob_flags_t       win [RET_W],
    input  logic [AVW-1:0]   avail,
    input  logic [CW-1:0]    cnt_in,
    input  logic             nb_mode,
    output logic [RET_W-1:0] rel,
    output logic [RET_W-1:0] drop,
    output logic [RET_W-1:0] mark_done,
    output logic [CW-1:0]    cnt_out
);

    logic          go;
    logic [CW-1:0] run;

    always_comb begin
        go        = 1'b1;
        run       = cnt_in;
        rel       = '0;
        drop      = '0;
        mark_done = '0;
        for (int k = 0; k < RET_W; k++) begin
            if (go && (k < int'(avail))) begin
                if (win[k].is_st && !win[k].rdy && win[k].addr_ok && !win[k].sdep
                    && (run < CW'(SB_CAP))) begin
                    rel[k] = 1'b1;
                    if (win[k].exc) begin
                        drop[k] = 1'b1;
                    end else begin
                        run = run + 1'b1;
                        if (nb_mode && !win[k].is_rmw) mark_done[k] = 1'b1;
                    end
                end else if (win[k].is_ucld && !win[k].rdy && win[k].addr_ok && !win[k].sdep) begin
                    rel[k]  = 1'b1;
                    drop[k] = win[k].exc;
                end
                if (!win[k].done || win[k].exc) go = 1'b0;
            end
        end
        cnt_out = run;
    end

endmodule

// File: rtl/rob_retire_ctl.sv
module rob_retire_ctl
    import rob_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int PREGS   = 64,
    parameter int RET_LAT = 1,
    localparam int IW     = $clog2(DEPTH),
    localparam int PW     = $clog2(PREGS),
    localparam int AW     = $clog2(RET_LAT + 2)
) (
    input  rob_flags_t     hd,
    input  logic [AW-1:0]  hd_age,
    input  logic [PW-1:0]  hd_preg,
    input  logic [IW-1:0]  hd_idx,
    input  logic           nonempty,
    output logic           retire,
    output logic           exc_valid,
    output logic [IW-1:0]  exc_idx,
    output logic           int_fv,
    output logic [PW-1:0]  int_fr,
    output logic           fp_fv,
    output logic [PW-1:0]  fp_fr,
    output logic           bar_pop
);

    logic settled;
    logic mem_hold;

    assign settled  = (hd.done || hd.exc) && (hd_age >= AW'(RET_LAT));
    assign mem_hold = hd.in_mem && !hd.exc;
    assign retire   = nonempty && hd.valid && settled && !mem_hold;

    assign exc_valid = retire && hd.exc;
    assign exc_idx   = hd_idx;
    assign fp_fv     = retire && !hd.exc && hd.fp;
    assign fp_fr     = hd_preg;
    assign int_fv    = retire && !hd.exc && !hd.fp && (hd_preg != '0);
    assign int_fr    = hd_preg;
    assign bar_pop   = retire && !hd.exc && hd.is_bar;

endmodule

// File: rtl/rob_retire_window.sv
module rob_retire_window
    import rob_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int RET_W   = 4,
    parameter int SB_CAP  = 8,
    parameter int RET_LAT = 1,
    parameter int PREGS   = 64,
    localparam int IW     = $clog2(DEPTH),
    localparam int PW     = $clog2(PREGS),
    localparam int CW     = $clog2(SB_CAP + 1),
    localparam int AW     = $clog2(RET_LAT + 2),
    localparam int AVW    = $clog2(RET_W + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic                nb_mode,
    input  logic                alloc_valid,
    input  logic                alloc_is_st,
    input  logic                alloc_is_ucld,
    input  logic                alloc_is_rmw,
    input  logic                alloc_is_bar,
    input  logic                alloc_fp,
    input  logic [PW-1:0]       alloc_preg,
    output logic                alloc_ready,
    output logic [IW-1:0]       alloc_tag,
    input  logic                cmp_valid,
    input  logic [IW-1:0]       cmp_idx,
    input  logic                cmp_exc,
    input  logic                agen_valid,
    input  logic [IW-1:0]       agen_idx,
    input  logic                agen_sdep,
    input  logic                st_issue,
    output logic [RET_W-1:0]    rel_valid,
    output logic [RET_W-1:0]    rel_drop,
    output logic [RET_W*IW-1:0] rel_idx,
    output logic                int_free_valid,
    output logic [PW-1:0]       int_free_reg,
    output logic                fp_free_valid,
    output logic [PW-1:0]       fp_free_reg,
    output logic                exc_valid,
    output logic [IW-1:0]       exc_idx,
    output logic                bar_pop,
    output logic                sync_busy
);

    rob_flags_t    flags_q [DEPTH];
    logic [AW-1:0] age_q   [DEPTH];
    logic [PW-1:0] preg_q  [DEPTH];
    logic [IW:0]   head_q, tail_q;
    logic [CW-1:0] cnt_q, cnt_scan;
    logic          sync_q;

    logic [IW:0]      count;
    logic             full;
    logic [AVW-1:0]   avail;
    logic [IW-1:0]    head_idx;
    logic [IW-1:0]    win_idx [RET_W];
    rob_flags_t       win     [RET_W];
    logic [RET_W-1:0] mark_done;
    logic             retire;

    assign count       = tail_q - head_q;
    assign full        = (count == (IW+1)'(DEPTH));
    assign alloc_ready = !full;
    assign alloc_tag   = tail_q[IW-1:0];
    assign head_idx    = head_q[IW-1:0];
    assign avail       = (count >= (IW+1)'(RET_W)) ? AVW'(RET_W) : AVW'(count);
    assign sync_busy   = sync_q;

    for (genvar k = 0; k < RET_W; k++) begin : g_win
        assign win_idx[k]             = head_idx + IW'(k);
        assign win[k]                 = flags_q[win_idx[k]];
        assign rel_idx[k*IW +: IW]    = win_idx[k];
    end

    rob_release_scan #(.RET_W(RET_W), .SB_CAP(SB_CAP)) u_scan (
        .win       (win),
        .avail     (avail),
        .cnt_in    (cnt_q),
        .nb_mode   (nb_mode),
        .rel       (rel_valid),
        .drop      (rel_drop),
        .mark_done (mark_done),
        .cnt_out   (cnt_scan)
    );

    rob_retire_ctl #(.DEPTH(DEPTH), .PREGS(PREGS), .RET_LAT(RET_LAT)) u_ret (
        .hd        (flags_q[head_idx]),
        .hd_age    (age_q[head_idx]),
        .hd_preg   (preg_q[head_idx]),
        .hd_idx    (head_idx),
        .nonempty  (count != '0),
        .retire    (retire),
        .exc_valid (exc_valid),
        .exc_idx   (exc_idx),
        .int_fv    (int_free_valid),
        .int_fr    (int_free_reg),
        .fp_fv     (fp_free_valid),
        .fp_fr     (fp_free_reg),
        .bar_pop   (bar_pop)
    );

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < DEPTH; i++) flags_q[i] <= '0;
            cnt_q  <= '0;
            sync_q <= 1'b0;
            if (rst) begin
                head_q <= '0;
                tail_q <= '0;
            end else begin
                tail_q <= head_q;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (flags_q[i].valid && (flags_q[i].done || flags_q[i].exc)
                    && (age_q[i] < AW'(RET_LAT)))
                    age_q[i] <= age_q[i] + 1'b1;
            end
            if (cmp_valid && flags_q[cmp_idx].valid) begin
                flags_q[cmp_idx].done <= 1'b1;
                if (cmp_exc) flags_q[cmp_idx].exc <= 1'b1;
            end
            if (agen_valid && flags_q[agen_idx].valid) begin
                flags_q[agen_idx].addr_ok <= 1'b1;
                flags_q[agen_idx].sdep    <= agen_sdep;
            end
            for (int k = 0; k < RET_W; k++) begin
                if (rel_valid[k]) begin
                    flags_q[win_idx[k]].rdy    <= 1'b1;
                    flags_q[win_idx[k]].in_mem <= 1'b0;
                end
                if (mark_done[k]) flags_q[win_idx[k]].done <= 1'b1;
            end
            if (retire) begin
                flags_q[head_idx].valid <= 1'b0;
                head_q <= head_q + 1'b1;
            end
            cnt_q <= (st_issue && (cnt_scan != '0)) ? cnt_scan - 1'b1 : cnt_scan;
            if (alloc_valid && !full && alloc_is_bar) sync_q <= 1'b1;
            else if (bar_pop)                         sync_q <= 1'b0;
            if (alloc_valid && !full) begin
                flags_q[alloc_tag] <= new_entry(alloc_is_st, alloc_is_ucld, alloc_is_rmw,
                                                alloc_is_bar, alloc_fp);
                age_q[alloc_tag]   <= '0;
                preg_q[alloc_tag]  <= alloc_preg;
                tail_q <= tail_q + 1'b1;
            end
        end
    end

    a_r1_full_refuse: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && full && !flush) |=> $stable(tail_q));

    a_r3_credit_cap: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(SB_CAP));

    a_r7_need_done: assert property (@(posedge clk) disable iff (rst)
        retire |-> (flags_q[head_idx].done || flags_q[head_idx].exc));

    a_r8_hold_unreleased: assert property (@(posedge clk) disable iff (rst)
        (count != '0 && flags_q[head_idx].in_mem && !flags_q[head_idx].exc) |-> !retire);

    a_r10_int_zero: assert property (@(posedge clk) disable iff (rst)
        int_free_valid |-> (int_free_reg != '0));

    a_r12_flush_empty: assert property (@(posedge clk) disable iff (rst)
        flush |=> (tail_q == head_q && cnt_q == '0));

    for (genvar k = 0; k < RET_W; k++) begin : g_chk
        a_r2_window: assert property (@(posedge clk) disable iff (rst)
            rel_valid[k] |-> (k < int'(avail)));
    end

endmodule

// File: tb/rob_retire_window_bench.sv
`timescale 1ns/1ps
module rob_retire_window_bench;

    localparam int DEPTH = 32, RW = 4, CAP = 3, LAT = 1, PREGS = 64;
    localparam int IW = $clog2(DEPTH), PW = $clog2(PREGS);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, flush, nb_mode, alloc_valid, a_st, a_ld, a_rmw, a_bar, a_fp;
    logic [PW-1:0] a_preg;
    logic alloc_ready;
    logic [IW-1:0] alloc_tag;
    logic cmp_valid, cmp_exc, agen_valid, agen_sdep, st_issue;
    logic [IW-1:0] cmp_idx, agen_idx;
    logic [RW-1:0] rel_valid, rel_drop;
    logic [RW*IW-1:0] rel_idx;
    logic int_fv, fp_fv, exc_valid, bar_pop, sync_busy;
    logic [PW-1:0] int_fr, fp_fr;
    logic [IW-1:0] exc_idx;

    rob_retire_window #(.DEPTH(DEPTH), .RET_W(RW), .SB_CAP(CAP), .RET_LAT(LAT), .PREGS(PREGS))
    u_rob_retire_window (
        .clk(clk), .rst(rst), .flush(flush), .nb_mode(nb_mode),
        .alloc_valid(alloc_valid), .alloc_is_st(a_st), .alloc_is_ucld(a_ld),
        .alloc_is_rmw(a_rmw), .alloc_is_bar(a_bar), .alloc_fp(a_fp), .alloc_preg(a_preg),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_exc(cmp_exc),
        .agen_valid(agen_valid), .agen_idx(agen_idx), .agen_sdep(agen_sdep),
        .st_issue(st_issue),
        .rel_valid(rel_valid), .rel_drop(rel_drop), .rel_idx(rel_idx),
        .int_free_valid(int_fv), .int_free_reg(int_fr),
        .fp_free_valid(fp_fv), .fp_free_reg(fp_fr),
        .exc_valid(exc_valid), .exc_idx(exc_idx),
        .bar_pop(bar_pop), .sync_busy(sync_busy)
    );

    int n_chk = 0, n_fail = 0;

    // behavioural model state
    bit m_v[DEPTH], m_done[DEPTH], m_exc[DEPTH], m_st[DEPTH], m_ld[DEPTH], m_rmw[DEPTH];
    bit m_bar[DEPTH], m_fp[DEPTH], m_addr[DEPTH], m_sdep[DEPTH], m_rdy[DEPTH], m_inm[DEPTH];
    int m_age[DEPTH], m_preg[DEPTH];
    int m_head, m_tail, m_cnt;
    bit m_sync;

    logic [RW-1:0] e_rel, e_drop, e_md;
    int e_run, e_excidx, e_reg;
    bit e_ret, e_exc, e_int, e_fp, e_bar;

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
        m_head = 0; m_tail = 0; m_cnt = 0; m_sync = 0;
    endtask

    task automatic compute();
        int held, av, run;
        bit go;
        held = m_tail - m_head;
        av = (held < RW) ? held : RW;
        go = 1; run = m_cnt;
        e_rel = '0; e_drop = '0; e_md = '0;
        for (int k = 0; k < RW; k++) begin
            if (go && k < av) begin
                int i;
                i = (m_head + k) % DEPTH;
                if (m_st[i] && !m_rdy[i] && m_addr[i] && !m_sdep[i] && run < CAP) begin
                    e_rel[k] = 1;
                    if (m_exc[i]) e_drop[k] = 1;
                    else begin
                        run++;
                        if (nb_mode && !m_rmw[i]) e_md[k] = 1;
                    end
                end else if (m_ld[i] && !m_rdy[i] && m_addr[i] && !m_sdep[i]) begin
                    e_rel[k] = 1;
                    e_drop[k] = m_exc[i];
                end
                if (!m_done[i] || m_exc[i]) go = 0;
            end
        end
        e_run = run;
        e_ret = 0; e_exc = 0; e_int = 0; e_fp = 0; e_bar = 0; e_excidx = 0; e_reg = 0;
        if (held > 0) begin
            int h;
            h = m_head % DEPTH;
            e_excidx = h;
            e_reg = m_preg[h];
            if ((m_done[h] || m_exc[h]) && m_age[h] >= LAT && !(m_inm[h] && !m_exc[h])) begin
                e_ret = 1;
                if (m_exc[h]) e_exc = 1;
                else begin
                    if (m_fp[h]) e_fp = 1;
                    else if (m_preg[h] != 0) e_int = 1;
                    e_bar = m_bar[h];
                end
            end
        end
    endtask

    task automatic compare();
        logic [RW*IW-1:0] eidx;
        for (int k = 0; k < RW; k++) eidx[k*IW +: IW] = IW'((m_head + k) % DEPTH);
        check("R1 alloc_ready", alloc_ready, (m_tail - m_head) < DEPTH);
        check("R1 alloc_tag", alloc_tag, m_tail % DEPTH);
        check("R2 R3 R4 R6 rel_valid", rel_valid, e_rel);
        check("R5 rel_drop", rel_drop, e_drop);
        check("R2 rel_idx", rel_idx, eidx);
        check("R7 R8 R10 int_free_valid", int_fv, e_int);
        if (e_int) check("R10 int_free_reg", int_fr, e_reg);
        check("R7 R8 R10 fp_free_valid", fp_fv, e_fp);
        if (e_fp) check("R10 fp_free_reg", fp_fr, e_reg);
        check("R9 exc_valid", exc_valid, e_exc);
        if (e_exc) check("R9 exc_idx", exc_idx, e_excidx);
        check("R11 bar_pop", bar_pop, e_bar);
        check("R11 R12 sync_busy", sync_busy, m_sync);
    endtask

    task automatic update();
        int held;
        held = m_tail - m_head;
        if (flush) begin
            for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
            m_tail = m_head; m_cnt = 0; m_sync = 0;
            return;
        end
        for (int i = 0; i < DEPTH; i++)
            if (m_v[i] && (m_done[i] || m_exc[i]) && m_age[i] < LAT) m_age[i]++;
        if (cmp_valid && m_v[cmp_idx]) begin
            m_done[cmp_idx] = 1;
            if (cmp_exc) m_exc[cmp_idx] = 1;
        end
        if (agen_valid && m_v[agen_idx]) begin
            m_addr[agen_idx] = 1;
            m_sdep[agen_idx] = agen_sdep;
        end
        for (int k = 0; k < RW; k++) begin
            int i;
            i = (m_head + k) % DEPTH;
            if (e_rel[k]) begin m_rdy[i] = 1; m_inm[i] = 0; end
            if (e_md[k]) m_done[i] = 1;
        end
        if (e_ret) begin m_v[m_head % DEPTH] = 0; m_head++; end
        m_cnt = e_run;
        if (st_issue && m_cnt > 0) m_cnt--;
        if (alloc_valid && held < DEPTH && a_bar) m_sync = 1;
        else if (e_bar) m_sync = 0;
        if (alloc_valid && held < DEPTH) begin
            int t;
            t = m_tail % DEPTH;
            m_v[t] = 1; m_done[t] = 0; m_exc[t] = 0; m_st[t] = a_st; m_ld[t] = a_ld;
            m_rmw[t] = a_rmw; m_bar[t] = a_bar; m_fp[t] = a_fp; m_addr[t] = 0;
            m_sdep[t] = 0; m_rdy[t] = 0; m_inm[t] = a_st | a_ld; m_age[t] = 0;
            m_preg[t] = int'(a_preg);
            m_tail++;
        end
    endtask

    task automatic clr_in();
        flush = 0; alloc_valid = 0; a_st = 0; a_ld = 0; a_rmw = 0; a_bar = 0; a_fp = 0;
        a_preg = '0; cmp_valid = 0; cmp_idx = '0; cmp_exc = 0;
        agen_valid = 0; agen_idx = '0; agen_sdep = 0; st_issue = 0;
    endtask

    // inputs are set at the falling edge; outputs compared 1 ns later
    task automatic step();
        #1;
        compute();
        compare();
        @(posedge clk);
        update();
        @(negedge clk);
        clr_in();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic alloc(bit st, bit ld, bit rmw, bit bar, bit fp, int preg);
        alloc_valid = 1; a_st = st; a_ld = ld; a_rmw = rmw; a_bar = bar; a_fp = fp;
        a_preg = PW'(preg);
        step();
    endtask

    task automatic complete(int idx, bit ex);
        cmp_valid = 1; cmp_idx = IW'(idx); cmp_exc = ex;
        step();
    endtask

    task automatic agen(int idx, bit sd);
        agen_valid = 1; agen_idx = IW'(idx); agen_sdep = sd;
        step();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int base;
        clr_in(); nb_mode = 0; rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        model_reset();
        // reset state (R1 R11)
        check("R1 reset alloc_ready", alloc_ready, 1);
        check("R2 reset rel_valid", rel_valid, 0);
        check("R11 reset sync_busy", sync_busy, 0);

        // plain ops, out-of-order completion, register classes (R7 R10)
        base = m_tail % DEPTH;
        alloc(0,0,0,0,0,5); alloc(0,0,0,0,0,0); alloc(0,0,0,0,1,9); alloc(0,0,0,0,0,7);
        complete((base+2)%DEPTH, 0); complete(base, 0); complete((base+1)%DEPTH, 0);
        complete((base+3)%DEPTH, 0);
        idle(8);

        // non-blocking stores against the credit limit (R3 R4)
        nb_mode = 1;
        base = m_tail % DEPTH;
        for (int i = 0; i < 5; i++) alloc(1,0,0,0,0,i+1);
        for (int i = 0; i < 5; i++) agen((base+i)%DEPTH, 0);
        idle(10);
        for (int i = 0; i < 4; i++) begin st_issue = 1; step(); end
        idle(10);
        for (int i = 0; i < 4; i++) begin st_issue = 1; step(); end

        // read-modify-write store stays until completion (R4)
        base = m_tail % DEPTH;
        alloc(1,0,1,0,0,11); agen(base, 0); idle(4); complete(base, 0); idle(4);

        // blocking faulting store (R5 R9)
        nb_mode = 0;
        base = m_tail % DEPTH;
        alloc(1,0,0,0,0,12); complete(base, 1); agen(base, 0); idle(6);

        // uncached load held by a structural hazard (R6 R8)
        base = m_tail % DEPTH;
        alloc(0,1,0,0,0,13); agen(base, 1); idle(3); agen(base, 0); idle(3);
        complete(base, 0); idle(5);

        // barrier (R11)
        base = m_tail % DEPTH;
        alloc(0,0,0,1,0,14); idle(2); complete(base, 0); idle(5);

        // fill beyond capacity, then flush (R1 R12)
        for (int i = 0; i < DEPTH + 2; i++) alloc(0,0,0,i == 3,0,i);
        check("R1 full refuses", alloc_ready, 0);
        flush = 1; step(); idle(2);

        // mixed random traffic
        for (int c = 0; c < 3000; c++) begin
            int held, r;
            held = m_tail - m_head;
            if (c % 500 == 0) nb_mode = ~nb_mode;
            if ($urandom % 3 != 0) begin
                r = $urandom % 8;
                alloc_valid = 1;
                a_st = (r < 2); a_rmw = (r == 1); a_ld = (r == 2); a_bar = (r == 3);
                a_fp = (r > 3) && ($urandom % 2 == 1);
                a_preg = ($urandom % 8 == 0) ? '0 : PW'($urandom);
            end
            if (held > 0 && $urandom % 2 == 0) begin
                cmp_valid = 1;
                cmp_idx = IW'((m_head + $urandom % held) % DEPTH);
                cmp_exc = ($urandom % 24 == 0);
            end
            if (held > 0 && $urandom % 2 == 0) begin
                agen_valid = 1;
                agen_idx = IW'((m_head + $urandom % held) % DEPTH);
                agen_sdep = ($urandom % 4 == 0);
            end
            st_issue = ($urandom % 3 == 0);
            flush = ($urandom % 250 == 0);
            step();
        end
        idle(4);
        finish_run();
    end

endmodule